// File: doc/BRIEF.md
# CD Serial Sample Receiver

This block sits between an external CD signal processor and a sector decoder. It takes the processor's three-wire serial stream (bit clock, left/right word clock, serial data) together with a C2 error flag and an emphasis flag. All of these lines are sampled in the core clock domain, and each 16-bit sample is rebuilt from its slot. Every sample is then handed on as two bytes, each carrying an error flag.

Processors differ in how they frame the stream, so four configuration inputs adapt the receiver to them. These are the slot length per word-clock half (24 or 32 bit clocks), the bit order, where the 16 data bits sit inside the slot, and which bit-clock edge samples the data. A new configuration is taken only at a word-clock transition, so a sample already being received is never split across two formats.

Top module: `cdsr_rx`

## Requirements
- R1: During and after reset, byte_vld_o, byte_hi_o, byte_err_o, byte_o and emph_o are 0. The active configuration resets to 24-bit slots, LSB first, front packing, rising edge.
- R2: Each word-clock half is a slot of 24 bit positions when cfg_slot32_i is 0, and 32 when it is 1. Bit-clock edges beyond the slot length produce no data.
- R3: With cfg_msb_first_i=1, the first valid serial bit is sample bit 15. With 0, it is sample bit 0.
- R4: With cfg_rear_pack_i=1, the 16 valid bits are the last 16 positions of the slot. With 0, they are the first 16. Data on the other positions is ignored.
- R5: With cfg_fall_edge_i=1, data is sampled on falling bit-clock edges. With 0, it is sampled on rising edges. The opposite edge is ignored.
- R6: Each sample leaves as two byte_vld_o pulses on consecutive cycles. The first carries bits 7:0 with byte_hi_o=0, and the second carries bits 15:8 with byte_hi_o=1. byte_hi_o is 0 whenever byte_vld_o is 0.
- R7: byte_err_o on both bytes of a sample is the OR of c2_i taken at that sample's 16 valid bit positions. c2_i on other positions has no effect.
- R8: The configuration inputs are loaded only at a word-clock transition. Changing them in the middle of a slot does not alter how that slot is decoded.
- R9: Every word-clock transition restarts the slot position count. A slot cut short before its last valid bit emits no bytes.
- R10: emph_o follows emph_i after synchronization, within a few core cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_slot32_i | input | 1 | 1: 32-position slots, 0: 24 |
| cfg_msb_first_i | input | 1 | 1: MSB first, 0: LSB first |
| cfg_rear_pack_i | input | 1 | 1: data at slot end, 0: at slot start |
| cfg_fall_edge_i | input | 1 | 1: sample on falling bit clock, 0: rising |
| bck_i | input | 1 | Serial bit clock (asynchronous) |
| lrck_i | input | 1 | Left/right word clock (asynchronous) |
| sdata_i | input | 1 | Serial data |
| c2_i | input | 1 | C2 error flag from the processor |
| emph_i | input | 1 | Emphasis flag from the processor |
| byte_o | output | 8 | Received byte |
| byte_vld_o | output | 1 | byte_o valid strobe |
| byte_hi_o | output | 1 | 1 for the upper byte of a sample |
| byte_err_o | output | 1 | C2 error attached to the byte |
| emph_o | output | 1 | Synchronized emphasis status |

## Verification
The hardest case to reach from the ports is a configuration change that arrives while a slot is still being received. Only the held copy of the configuration stops that slot from being misdecoded. The stimulus starts a slot in one format and inverts all four configuration inputs a few bits in. It keeps serializing in the original format, then expects the original word. Truncated slots are reached by issuing a word-clock transition before the last valid bit. Padding positions carry alternating data and an asserted C2 flag, so any leak out of the valid window shows up in the bytes.

// File: rtl/cdsr_pkg.sv
package cdsr_pkg;
  localparam int unsigned WORD_W     = 16;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned SLOT_SHORT = 24;
  localparam int unsigned SLOT_LONG  = 32;
  localparam int unsigned CNT_W      = $clog2(SLOT_LONG + 1);
  localparam int unsigned SYNC_W     = 5;

  typedef struct packed {
    logic slot32;
    logic msb_first;
    logic rear_pack;
    logic fall_edge;
  } cdsr_cfg_t;
endpackage

// File: rtl/cdsr_sync.sv
module cdsr_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cdsr_edge.sv
module cdsr_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bck_s_i,
  input  logic lrck_s_i,
  input  logic fall_sel_i,
  output logic act_edge_o,
  output logic lr_evt_o
);
  logic bck_d, lrck_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bck_d  <= 1'b0;
      lrck_d <= 1'b0;
    end else begin
      bck_d  <= bck_s_i;
      lrck_d <= lrck_s_i;
    end
  end

  assign act_edge_o = fall_sel_i ? (bck_d & ~bck_s_i) : (~bck_d & bck_s_i);
  assign lr_evt_o   = lrck_d ^ lrck_s_i;
endmodule

// File: rtl/cdsr_deser.sv
module cdsr_deser
  import cdsr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cdsr_cfg_t         cfg_i,
  input  logic              lr_evt_i,
  input  logic              act_edge_i,
  input  logic              sdata_i,
  input  logic              c2_i,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o,
  output logic              err_o
);
  logic [CNT_W-1:0]  cnt_q, slot_len, win_lo;
  logic [WORD_W-1:0] sh_q, sh_nxt;
  logic              acc_q, acc_nxt, in_win, last_bit;

  always_comb begin
    slot_len = cfg_i.slot32 ? CNT_W'(SLOT_LONG) : CNT_W'(SLOT_SHORT);
    win_lo   = cfg_i.rear_pack ? slot_len - CNT_W'(WORD_W) : '0;
    in_win   = (cnt_q >= win_lo) && (cnt_q < win_lo + CNT_W'(WORD_W));
    last_bit = (cnt_q == win_lo + CNT_W'(WORD_W - 1));
    sh_nxt   = cfg_i.msb_first ? {sh_q[WORD_W-2:0], sdata_i}
                               : {sdata_i, sh_q[WORD_W-1:1]};
    acc_nxt  = (cnt_q == win_lo) ? c2_i : (acc_q | c2_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      acc_q  <= 1'b0;
      done_o <= 1'b0;
      word_o <= '0;
      err_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (lr_evt_i) begin
        cnt_q <= '0;  // slot boundary; an edge in this cycle is dropped
      end else if (act_edge_i) begin
        if (cnt_q < slot_len) cnt_q <= cnt_q + 1'b1;
        if (in_win) begin
          sh_q  <= sh_nxt;
          acc_q <= acc_nxt;
          if (last_bit) begin
            done_o <= 1'b1;
            word_o <= sh_nxt;
            err_o  <= acc_nxt;
          end
        end
      end
    end
  end
endmodule

// File: rtl/cdsr_byte_out.sv
module cdsr_byte_out
  import cdsr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              err_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              vld_o,
  output logic              last_o,
  output logic              err_o
);
  localparam int unsigned NB    = WORD_W / BYTE_W;
  localparam int unsigned REM_W = $clog2(NB + 1);

  logic [WORD_W-1:0] hold_q;
  logic [REM_W-1:0]  rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      rem_q  <= '0;
      byte_o <= '0;
      vld_o  <= 1'b0;
      last_o <= 1'b0;
      err_o  <= 1'b0;
    end else if (done_i) begin
      byte_o <= word_i[BYTE_W-1:0];
      hold_q <= word_i >> BYTE_W;
      rem_q  <= REM_W'(NB - 1);
      vld_o  <= 1'b1;
      last_o <= (NB == 1);
      err_o  <= err_i;
    end else if (rem_q != '0) begin
      byte_o <= hold_q[BYTE_W-1:0];
      hold_q <= hold_q >> BYTE_W;
      rem_q  <= rem_q - 1'b1;
      vld_o  <= 1'b1;
      last_o <= (rem_q == REM_W'(1));
    end else begin
      vld_o  <= 1'b0;
      last_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cdsr_rx.sv
module cdsr_rx
  import cdsr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_slot32_i,
  input  logic             cfg_msb_first_i,
  input  logic             cfg_rear_pack_i,
  input  logic             cfg_fall_edge_i,
  input  logic             bck_i,
  input  logic             lrck_i,
  input  logic             sdata_i,
  input  logic             c2_i,
  input  logic             emph_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic             byte_vld_o,
  output logic             byte_hi_o,
  output logic             byte_err_o,
  output logic             emph_o
);
  logic [SYNC_W-1:0] raw, syn;
  cdsr_cfg_t         cfg_q;
  logic              act_edge, lr_evt, done, err;
  logic [WORD_W-1:0] word;

  assign raw = {emph_i, c2_i, sdata_i, lrck_i, bck_i};

  cdsr_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn)
  );

  cdsr_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .bck_s_i(syn[0]), .lrck_s_i(syn[1]),
    .fall_sel_i(cfg_q.fall_edge), .act_edge_o(act_edge), .lr_evt_o(lr_evt)
  );

  // format is taken only at slot boundaries
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (lr_evt)
      cfg_q <= '{slot32: cfg_slot32_i, msb_first: cfg_msb_first_i,
                 rear_pack: cfg_rear_pack_i, fall_edge: cfg_fall_edge_i};
  end

  cdsr_deser u_deser (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_i(cfg_q), .lr_evt_i(lr_evt),
    .act_edge_i(act_edge), .sdata_i(syn[2]), .c2_i(syn[3]),
    .done_o(done), .word_o(word), .err_o(err)
  );

  cdsr_byte_out u_bytes (
    .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done), .word_i(word), .err_i(err),
    .byte_o(byte_o), .vld_o(byte_vld_o), .last_o(byte_hi_o), .err_o(byte_err_o)
  );

  assign emph_o = syn[4];
endmodule

// File: rtl/cdsr_rx_chk.sv
module cdsr_rx_chk
  import cdsr_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      byte_vld_i,
  input logic      byte_hi_i,
  input logic      byte_err_i,
  input logic      lr_evt_i,
  input cdsr_cfg_t cfg_q_i
);
  a_r6_lo_then_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && !byte_hi_i) |=> (byte_vld_i && byte_hi_i));

  a_r6_hi_after_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && byte_hi_i) |-> $past(byte_vld_i && !byte_hi_i));

  a_r6_hi_only_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld_i |-> !byte_hi_i);

  a_r7_err_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && byte_hi_i) |-> (byte_err_i == $past(byte_err_i)));

  a_r8_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lr_evt_i |=> $stable(cfg_q_i));
endmodule

bind cdsr_rx cdsr_rx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .byte_vld_i(byte_vld_o), .byte_hi_i(byte_hi_o),
  .byte_err_i(byte_err_o), .lr_evt_i(lr_evt), .cfg_q_i(cfg_q)
);

// File: tb/cdsr_rx_bench.sv
`timescale 1ns/1ps
module cdsr_rx_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_s32 = 0, cfg_msb = 0, cfg_rear = 0, cfg_fall = 0;
  logic bck = 0, lrck = 0, sd = 0, c2 = 0, emph = 0;
  logic [7:0] byte_o;
  logic byte_vld_o, byte_hi_o, byte_err_o, emph_o;

  always #2 clk = ~clk;

  cdsr_rx u_cdsr_rx (
    .clk_i(clk), .rst_ni(rst_n), .cfg_slot32_i(cfg_s32), .cfg_msb_first_i(cfg_msb),
    .cfg_rear_pack_i(cfg_rear), .cfg_fall_edge_i(cfg_fall), .bck_i(bck), .lrck_i(lrck),
    .sdata_i(sd), .c2_i(c2), .emph_i(emph), .byte_o(byte_o), .byte_vld_o(byte_vld_o),
    .byte_hi_o(byte_hi_o), .byte_err_o(byte_err_o), .emph_o(emph_o)
  );

  int checks = 0, fails = 0;
  logic [7:0] got_b [256];
  logic       got_h [256];
  logic       got_e [256];
  int         got_n = 0;

  always @(negedge clk) begin
    if (rst_n && byte_vld_o && got_n < 256) begin
      got_b[got_n] <= byte_o;
      got_h[got_n] <= byte_hi_o;
      got_e[got_n] <= byte_err_o;
      got_n <= got_n + 1;
    end
  end

  // {slot32, msb_first, rear_pack, fall_edge, c2, word}
  localparam logic [20:0] VEC [16] = '{
    {5'b00000, 16'hA51C}, {5'b00010, 16'h7E81}, {5'b00100, 16'hC3D2}, {5'b00111, 16'h0F1E},
    {5'b01000, 16'h8001}, {5'b01010, 16'h5AA5}, {5'b01101, 16'hB6E7}, {5'b01110, 16'h2468},
    {5'b10001, 16'h1357}, {5'b10010, 16'hFEDC}, {5'b10100, 16'h0001}, {5'b10110, 16'h8000},
    {5'b11001, 16'h9ABC}, {5'b11010, 16'hDEF0}, {5'b11100, 16'h6D49}, {5'b11111, 16'hFFFF}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic set_cfg(input logic s, input logic m, input logic r, input logic f);
    cfg_s32 = s; cfg_msb = m; cfg_rear = r; cfg_fall = f;
  endtask

  // serializes n positions of one slot in format (s,m,r,f); flips cfg inputs at flip_at
  task automatic send_slot(input logic s, input logic m, input logic r, input logic f,
                           input logic [15:0] w, input logic c2v, input int n,
                           input int flip_at);
    int slot, wl;
    slot = s ? 32 : 24;
    wl   = r ? slot - 16 : 0;
    lrck = ~lrck;
    half();
    bck = f;
    half();
    for (int p = 0; p < n; p++) begin
      if (p == flip_at) {cfg_s32, cfg_msb, cfg_rear, cfg_fall} = ~{cfg_s32, cfg_msb, cfg_rear, cfg_fall};
      if (p >= wl && p < wl + 16) begin
        sd = m ? w[15 - (p - wl)] : w[p - wl];
        c2 = c2v;
      end else begin
        sd = p[0];
        c2 = 1'b1;
      end
      half();
      bck = ~bck;
      half();
      bck = ~bck;
    end
    sd = 0;
    c2 = 0;
    repeat (10) @(posedge clk);
    #1;
  endtask

  task automatic expect_word(input int base, input logic [15:0] w, input logic e, input string tag);
    chk(got_n == base + 2, {tag, " byte count"}, got_n, base + 2);
    if (got_n >= base + 2) begin
      chk(got_b[base] == w[7:0] && !got_h[base] && got_e[base] == e,
          {tag, " low byte"}, {got_h[base], got_e[base], got_b[base]}, {1'b0, e, w[7:0]});
      chk(got_b[base+1] == w[15:8] && got_h[base+1] && got_e[base+1] == e,
          {tag, " high byte"}, {got_h[base+1], got_e[base+1], got_b[base+1]}, {1'b1, e, w[15:8]});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int base;
    // R1: reset state
    repeat (4) @(negedge clk);
    chk({byte_vld_o, byte_hi_o, byte_err_o, emph_o, byte_o} == '0, "R1 in reset",
        {byte_vld_o, byte_hi_o, byte_err_o, emph_o, byte_o}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({byte_vld_o, byte_hi_o, byte_err_o, emph_o, byte_o} == '0, "R1 after reset",
        {byte_vld_o, byte_hi_o, byte_err_o, emph_o, byte_o}, 0);
    @(posedge clk); #1;

    // R2 R3 R4 R5 R6 R7: every format combination, padding carries junk and C2=1
    for (int i = 0; i < 16; i++) begin
      base = got_n;
      set_cfg(VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17]);
      send_slot(VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][15:0], VEC[i][16],
                VEC[i][20] ? 32 : 24, -1);
      expect_word(base, VEC[i][15:0], VEC[i][16], $sformatf("R2 R3 R4 R5 R6 R7 vec%0d", i));
    end

    // R8: inputs change mid-slot, slot still decoded in the format it started with
    base = got_n;
    set_cfg(0, 1, 0, 0);
    send_slot(0, 1, 0, 0, 16'h3C5A, 0, 24, 5);
    expect_word(base, 16'h3C5A, 0, "R8 mid-slot cfg change");

    // R9: truncated slots emit nothing
    base = got_n;
    set_cfg(0, 0, 0, 0);
    send_slot(0, 0, 0, 0, 16'hFFFF, 0, 10, -1);
    chk(got_n == base, "R9 short front slot", got_n, base);
    set_cfg(0, 0, 1, 0);
    send_slot(0, 0, 1, 0, 16'hFFFF, 0, 20, -1);
    chk(got_n == base, "R9 short rear slot", got_n, base);
    send_slot(0, 0, 1, 0, 16'h1234, 1, 24, -1);
    expect_word(base, 16'h1234, 1, "R9 full slot after restart");

    // R2: extra bit-clock edges past slot end produce no data
    base = got_n;
    send_slot(0, 0, 1, 0, 16'h4321, 0, 30, -1);
    expect_word(base, 16'h4321, 0, "R2 overlong slot");

    // R10: emphasis status
    emph = 1'b1;
    repeat (6) @(negedge clk);
    chk(emph_o == 1'b1, "R10 emph set", emph_o, 1);
    @(posedge clk); #1 emph = 1'b0;
    repeat (6) @(negedge clk);
    chk(emph_o == 1'b0, "R10 emph clear", emph_o, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule